// File: doc/BRIEF.md
# In-Order Memory Response Buffer

This block sits between the issue stage of a vector memory pipeline and the memory system. Requests enter an issue FIFO in program order and launch from its head, one per cycle, provided the matching in-flight limit allows it. Each launched request receives a buffer entry tagged with a sequence number. Responses return from memory in any order and mark their entry complete.

Only the oldest entry is ever shown as ready, and only once its response has arrived. Completed younger entries stay hidden behind it. The oldest entry retires when the latency, return-bus and register-file-write conditions all hold. After a retirement the return bus stays occupied for a per-request number of cycles. Loads and atomics share one in-flight counter and stores use a second. Both are capped by the `QSIZE` parameter. End-of-kernel synchronisations launch without taking an entry or a sequence number. The block carries no data payload.

Top module: `mem_order_buf`

## Requirements
- R1: After synchronous reset, `req_ready` is 1 and `launch_valid`, `head_valid` and `retire_valid` are 0.
- R2: Request kinds are encoded on 3 bits: 0 load, 1 store, 2 atomic without return, 3 atomic with return, 4 sync, 5 end-of-kernel sync. The FIFO accepts a request when `req_valid` is high and `req_ready` is high. `req_ready` is low only while the FIFO holds `FIFO_DEPTH` requests. Requests launch strictly in arrival order, and a held head holds everything behind it.
- R3: A head of kind 0, 2 or 3 does not launch while `QSIZE` such requests are in flight (launched and not yet retired).
- R4: A head of kind 1 does not launch while `QSIZE` stores are in flight.
- R5: Every launch other than kind 5 shows on `launch_seq` a sequence number one greater (mod 2^`SEQ_W`) than the previous such launch, starting at 0. Kind 5 launches consume no number and create no entry.
- R6: A head that needs an entry (kinds 0 to 4) does not launch while 2*`QSIZE` entries are held.
- R7: A response whose `rsp_seq` names a held entry that is not yet complete marks it complete. Any other response raises `rsp_err` in the same cycle and changes nothing.
- R8: `head_valid` is high only when the oldest held entry is complete, and `head_seq` then shows its number. Completed younger entries are never shown.
- R9: `retire_valid` is high when `head_valid`, `lat_ready` and the return bus is free hold together. For kinds 0 and 3, `vrf_ok` must also be high. Retirement removes the oldest entry and frees its in-flight count.
- R10: After retiring an entry that carried busy value B, no retirement takes place in the next B cycles.
- R11: A count freed by a retirement may be used by a launch in the next cycle.
- R12: At most one launch and one retirement occur per cycle, and both may occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered to the issue FIFO |
| req_kind | input | 3 | Request kind code |
| req_busy | input | BUSY_W | Return-bus busy cycles after this request retires |
| req_ready | output | 1 | FIFO has room |
| launch_valid | output | 1 | FIFO head launches this cycle |
| launch_kind | output | 3 | Kind of the launching request |
| launch_seq | output | SEQ_W | Sequence number of the launching request |
| rsp_valid | input | 1 | Memory response arrives |
| rsp_seq | input | SEQ_W | Sequence number of the response |
| rsp_err | output | 1 | Response matched no pending entry |
| lat_ready | input | 1 | Pipeline latency condition met |
| vrf_ok | input | 1 | Register-file write port available |
| head_valid | output | 1 | Oldest entry is complete |
| head_seq | output | SEQ_W | Sequence number of the oldest entry |
| retire_valid | output | 1 | Oldest entry retires this cycle |
| retire_seq | output | SEQ_W | Sequence number being retired |
| retire_kind | output | 3 | Kind being retired |

## Verification
The interesting collisions are a launch and a retirement in the same cycle, where one counter is incremented and decremented at once, and a response arriving in the cycle the head retires. The bench provokes both with long runs of mixed kinds, random responses and randomly withheld ready inputs. A behavioural model built from queues predicts every output each cycle. It also counts the cycles in which a launch and a retirement coincide, so the run is judged to have reached that case.

// File: rtl/mob_pkg.sv
// Shared kind encoding and classification helpers for the in-order
// memory response buffer. Assumes a 3-bit kind code.
package mob_pkg;

    typedef enum logic [2:0] {
        MK_LOAD     = 3'd0,
        MK_STORE    = 3'd1,
        MK_ATOM     = 3'd2,
        MK_ATOM_RET = 3'd3,
        MK_SYNC     = 3'd4,
        MK_SYNC_EOK = 3'd5
    } mob_kind_e;

    // Kinds charged to the read-side in-flight counter.
    function automatic logic is_rd_class(input mob_kind_e k);
        return (k == MK_LOAD) || (k == MK_ATOM) || (k == MK_ATOM_RET);
    endfunction

    // Kinds charged to the write-side in-flight counter.
    function automatic logic is_wr_class(input mob_kind_e k);
        return (k == MK_STORE);
    endfunction

    // Kinds that occupy an ordering entry.
    function automatic logic needs_slot(input mob_kind_e k);
        return (k != MK_SYNC_EOK);
    endfunction

    // Kinds whose retirement writes the register file.
    function automatic logic needs_regwrite(input mob_kind_e k);
        return (k == MK_LOAD) || (k == MK_ATOM_RET);
    endfunction

endpackage

// File: rtl/mob_issue_fifo.sv
// Issue FIFO: holds requests in arrival order until they launch.
// Assumes the caller pops only when not empty; a push while full is dropped.
module mob_issue_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  store_q [DEPTH];
    logic [PW-1:0] rd_ptr_q, wr_ptr_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = store_q[rd_ptr_q];

    // Next pointer position with wrap at DEPTH.
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Payload storage, written at the tail.
    always_ff @(posedge clk) begin
        if (do_push) store_q[wr_ptr_q] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (do_push) wr_ptr_q <= bump(wr_ptr_q);
            if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/mob_launch_gate.sv
// Launch gate: decides whether the FIFO head may launch this cycle and
// keeps the read-side and write-side in-flight counters. Counters use
// registered values only; a retirement frees a count for the next cycle.
module mob_launch_gate import mob_pkg::*; #(
    parameter int QSIZE     = 4,
    parameter int BUF_DEPTH = 8,
    parameter int LCNT_W    = 3,
    parameter int BCNT_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              head_present,
    input  mob_kind_e         head_kind,
    input  logic [BCNT_W-1:0] buf_cnt,
    input  logic              retire_fire,
    input  mob_kind_e         retire_kind,
    output logic              launch_fire,
    output logic [LCNT_W-1:0] ld_cnt,
    output logic [LCNT_W-1:0] st_cnt
);
    logic ld_block, st_block, buf_block;
    logic ld_inc, ld_dec, st_inc, st_dec;

    // Hold conditions for the current head.
    always_comb begin
        ld_block  = is_rd_class(head_kind) && (ld_cnt >= LCNT_W'(QSIZE));
        st_block  = is_wr_class(head_kind) && (st_cnt >= LCNT_W'(QSIZE));
        buf_block = needs_slot(head_kind) && (buf_cnt >= BCNT_W'(BUF_DEPTH));
        launch_fire = head_present && !ld_block && !st_block && !buf_block;
    end

    assign ld_inc = launch_fire && is_rd_class(head_kind);
    assign st_inc = launch_fire && is_wr_class(head_kind);
    assign ld_dec = retire_fire && is_rd_class(retire_kind);
    assign st_dec = retire_fire && is_wr_class(retire_kind);

    // In-flight counters, each moved up on launch and down on retirement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_cnt <= '0;
            st_cnt <= '0;
        end else begin
            case ({ld_inc, ld_dec})
                2'b10:   ld_cnt <= ld_cnt + 1'b1;
                2'b01:   ld_cnt <= ld_cnt - 1'b1;
                default: ld_cnt <= ld_cnt;
            endcase
            case ({st_inc, st_dec})
                2'b10:   st_cnt <= st_cnt + 1'b1;
                2'b01:   st_cnt <= st_cnt - 1'b1;
                default: st_cnt <= st_cnt;
            endcase
        end
    end
endmodule

// File: rtl/mob_order_ring.sv
// Ordering ring: one entry per launched request, held in sequence order.
// Assumes DEPTH is a power of two and SEQ_W exceeds log2(DEPTH), so the
// low bits of a sequence number name its slot directly.
module mob_order_ring import mob_pkg::*; #(
    parameter int DEPTH  = 8,
    parameter int SEQ_W  = 8,
    parameter int BUSY_W = 3,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  mob_kind_e         alloc_kind,
    input  logic [BUSY_W-1:0] alloc_busy,
    input  logic              rsp_valid,
    input  logic [SEQ_W-1:0]  rsp_seq,
    output logic              rsp_err,
    input  logic              retire,
    output logic [CNT_W-1:0]  count,
    output logic [SEQ_W-1:0]  tail_seq,
    output logic              head_done,
    output logic [SEQ_W-1:0]  head_seq,
    output mob_kind_e         head_kind,
    output logic [BUSY_W-1:0] head_busy
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [SEQ_W-1:0]  head_seq_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DEPTH-1:0]  done_q;
    mob_kind_e         kind_q [DEPTH];
    logic [BUSY_W-1:0] busy_q [DEPTH];

    logic [PTR_W-1:0] head_ptr, tail_ptr, rsp_slot;
    logic [SEQ_W-1:0] rsp_off;
    logic             alloc_ok, rsp_hit, do_retire;

    // Slot decode and response matching against the live window.
    always_comb begin
        tail_seq  = head_seq_q + SEQ_W'(cnt_q);
        head_ptr  = head_seq_q[PTR_W-1:0];
        tail_ptr  = tail_seq[PTR_W-1:0];
        rsp_slot  = rsp_seq[PTR_W-1:0];
        rsp_off   = rsp_seq - head_seq_q;
        rsp_hit   = rsp_valid && (rsp_off < SEQ_W'(cnt_q)) && !done_q[rsp_slot];
        rsp_err   = rsp_valid && !rsp_hit;
        alloc_ok  = alloc && (cnt_q < CNT_W'(DEPTH));
        head_done = (cnt_q != '0) && done_q[head_ptr];
        do_retire = retire && head_done;
    end

    assign count     = cnt_q;
    assign head_seq  = head_seq_q;
    assign head_kind = kind_q[head_ptr];
    assign head_busy = busy_q[head_ptr];

    // Head sequence number and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_seq_q <= '0;
            cnt_q      <= '0;
        end else begin
            if (do_retire) head_seq_q <= head_seq_q + 1'b1;
            case ({alloc_ok, do_retire})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // Per-slot state: cleared on allocation, marked on a matching response.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                done_q[i] <= 1'b0;
                kind_q[i] <= MK_LOAD;
                busy_q[i] <= '0;
            end else if (alloc_ok && (tail_ptr == PTR_W'(i))) begin
                done_q[i] <= 1'b0;
                kind_q[i] <= alloc_kind;
                busy_q[i] <= alloc_busy;
            end else if (rsp_hit && (rsp_slot == PTR_W'(i))) begin
                done_q[i] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/mob_ret_timer.sv
// Return-bus occupancy timer: loaded with a busy count on retirement,
// counts down to zero; the bus is free only at zero.
module mob_ret_timer #(
    parameter int BUSY_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BUSY_W-1:0] load_val,
    output logic              bus_free
);
    logic [BUSY_W-1:0] left_q;

    assign bus_free = (left_q == '0);

    // Reload on retirement, otherwise count down.
    always_ff @(posedge clk) begin
        if (!rst_n)             left_q <= '0;
        else if (load)          left_q <= load_val;
        else if (left_q != '0)  left_q <= left_q - 1'b1;
    end
endmodule

// File: rtl/mem_order_buf.sv
// In-order memory response buffer top. Requests queue in an issue FIFO,
// launch under per-class in-flight caps, take an ordering entry, complete
// out of order and retire strictly oldest-first. Assumes QSIZE is a power
// of two and SEQ_W > log2(2*QSIZE).
module mem_order_buf import mob_pkg::*; #(
    parameter int QSIZE      = 4,
    parameter int FIFO_DEPTH = 4,
    parameter int SEQ_W      = 8,
    parameter int BUSY_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [BUSY_W-1:0] req_busy,
    output logic              req_ready,
    output logic              launch_valid,
    output logic [2:0]        launch_kind,
    output logic [SEQ_W-1:0]  launch_seq,
    input  logic              rsp_valid,
    input  logic [SEQ_W-1:0]  rsp_seq,
    output logic              rsp_err,
    input  logic              lat_ready,
    input  logic              vrf_ok,
    output logic              head_valid,
    output logic [SEQ_W-1:0]  head_seq,
    output logic              retire_valid,
    output logic [SEQ_W-1:0]  retire_seq,
    output logic [2:0]        retire_kind
);
    localparam int BUF_DEPTH = 2 * QSIZE;
    localparam int BCNT_W    = $clog2(BUF_DEPTH + 1);
    localparam int LCNT_W    = $clog2(QSIZE + 1);
    localparam int FW        = 3 + BUSY_W;

    logic [FW-1:0]     fifo_dout;
    logic              fifo_empty, fifo_full;
    mob_kind_e         fk;
    logic [BUSY_W-1:0] fbusy;
    logic              launch_fire;
    logic [LCNT_W-1:0] ld_cnt, st_cnt;
    logic [BCNT_W-1:0] buf_cnt;
    logic [SEQ_W-1:0]  tail_seq;
    logic              head_done, bus_free;
    mob_kind_e         ring_kind;
    logic [BUSY_W-1:0] retire_busy;

    assign fk    = mob_kind_e'(fifo_dout[FW-1 -: 3]);
    assign fbusy = fifo_dout[BUSY_W-1:0];

    mob_issue_fifo #(.DEPTH(FIFO_DEPTH), .W(FW)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (req_valid),
        .din   ({req_kind, req_busy}),
        .pop   (launch_fire),
        .dout  (fifo_dout),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    mob_launch_gate #(.QSIZE(QSIZE), .BUF_DEPTH(BUF_DEPTH),
                      .LCNT_W(LCNT_W), .BCNT_W(BCNT_W)) u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .head_present (!fifo_empty),
        .head_kind    (fk),
        .buf_cnt      (buf_cnt),
        .retire_fire  (retire_valid),
        .retire_kind  (ring_kind),
        .launch_fire  (launch_fire),
        .ld_cnt       (ld_cnt),
        .st_cnt       (st_cnt)
    );

    mob_order_ring #(.DEPTH(BUF_DEPTH), .SEQ_W(SEQ_W),
                     .BUSY_W(BUSY_W), .CNT_W(BCNT_W)) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc      (launch_fire && needs_slot(fk)),
        .alloc_kind (fk),
        .alloc_busy (fbusy),
        .rsp_valid  (rsp_valid),
        .rsp_seq    (rsp_seq),
        .rsp_err    (rsp_err),
        .retire     (retire_valid),
        .count      (buf_cnt),
        .tail_seq   (tail_seq),
        .head_done  (head_done),
        .head_seq   (head_seq),
        .head_kind  (ring_kind),
        .head_busy  (retire_busy)
    );

    mob_ret_timer #(.BUSY_W(BUSY_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (retire_valid),
        .load_val (retire_busy),
        .bus_free (bus_free)
    );

    // Port-level view of launch and retirement decisions.
    always_comb begin
        req_ready    = !fifo_full;
        launch_valid = launch_fire;
        launch_kind  = fk;
        launch_seq   = tail_seq;
        head_valid   = head_done;
        retire_valid = head_done && lat_ready && bus_free &&
                       (!needs_regwrite(ring_kind) || vrf_ok);
        retire_seq   = head_seq;
        retire_kind  = ring_kind;
    end
endmodule

// File: rtl/mem_order_buf_chk.sv
// Property checker for mem_order_buf, attached by bind below.
// Observes the top's ports and the counters that its submodules drive.
module mem_order_buf_chk #(
    parameter int QSIZE  = 4,
    parameter int SEQ_W  = 8,
    parameter int BUSY_W = 3,
    parameter int LCNT_W = 3,
    parameter int BCNT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              launch_valid,
    input logic [2:0]        launch_kind,
    input logic [LCNT_W-1:0] ld_cnt,
    input logic [LCNT_W-1:0] st_cnt,
    input logic [BCNT_W-1:0] buf_cnt,
    input logic [SEQ_W-1:0]  head_seq,
    input logic              retire_valid,
    input logic [BUSY_W-1:0] retire_busy
);
    // R2: a full FIFO with no launch stays full.
    a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !launch_valid) |=> !req_ready);

    // R3: read-class launch only below the cap.
    a_r3_load_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_valid && (launch_kind == 3'd0 || launch_kind == 3'd2 ||
                          launch_kind == 3'd3)) |-> (ld_cnt < LCNT_W'(QSIZE)));

    // R4: store launch only below the cap.
    a_r4_store_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_valid && launch_kind == 3'd1) |-> (st_cnt < LCNT_W'(QSIZE)));

    // R6: entry-taking launch only with room in the ring.
    a_r6_ring_room: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_valid && launch_kind != 3'd5) |-> (buf_cnt < BCNT_W'(2 * QSIZE)));

    // R8: each retirement advances the oldest sequence number by one.
    a_r8_oldest_first: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid |=> (head_seq == $past(head_seq) + 1'b1));

    // R10: a non-zero busy value blocks retirement in the following cycle.
    a_r10_bus_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_valid && retire_busy != '0) |=> !retire_valid);
endmodule

bind mem_order_buf mem_order_buf_chk #(
    .QSIZE(QSIZE), .SEQ_W(SEQ_W), .BUSY_W(BUSY_W),
    .LCNT_W(LCNT_W), .BCNT_W(BCNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .launch_valid (launch_valid),
    .launch_kind  (launch_kind),
    .ld_cnt       (ld_cnt),
    .st_cnt       (st_cnt),
    .buf_cnt      (buf_cnt),
    .head_seq     (head_seq),
    .retire_valid (retire_valid),
    .retire_busy  (retire_busy)
);

// File: tb/sim_mem_order_buf.sv
// Bench: queue-based reference model, compared with the outputs every cycle.
module sim_mem_order_buf;
    localparam int QSIZE = 4, FD = 4, SEQ_W = 8, BUSY_W = 3, BUFD = 2 * QSIZE;

    logic clk = 1'b0, rst_n = 1'b0;
    always #5 clk = ~clk;

    logic              req_valid = 0, rsp_valid = 0, lat_ready = 0, vrf_ok = 0;
    logic [2:0]        req_kind = 0;
    logic [BUSY_W-1:0] req_busy = 0;
    logic [SEQ_W-1:0]  rsp_seq = 0;
    logic              req_ready, launch_valid, rsp_err, head_valid, retire_valid;
    logic [2:0]        launch_kind, retire_kind;
    logic [SEQ_W-1:0]  launch_seq, head_seq, retire_seq;

    mem_order_buf #(.QSIZE(QSIZE), .FIFO_DEPTH(FD), .SEQ_W(SEQ_W), .BUSY_W(BUSY_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_busy(req_busy), .req_ready(req_ready), .launch_valid(launch_valid),
        .launch_kind(launch_kind), .launch_seq(launch_seq), .rsp_valid(rsp_valid),
        .rsp_seq(rsp_seq), .rsp_err(rsp_err), .lat_ready(lat_ready), .vrf_ok(vrf_ok),
        .head_valid(head_valid), .head_seq(head_seq), .retire_valid(retire_valid),
        .retire_seq(retire_seq), .retire_kind(retire_kind));

    typedef struct { int seq; int kind; int busy; bit done; } ent_t;
    typedef struct { int kind; int busy; } req_t;
    req_t mq[$];
    ent_t ring[$];
    int   pend[$];
    int   m_ld = 0, m_st = 0, m_timer = 0, m_next = 0;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    int launches = 0, both_cnt = 0, err_cnt = 0, held_cnt = 0;
    int last_ret = -100, min_gap = 1000;
    bit finished = 0;

    // Stimulus knobs.
    int p_req = 0, kind_sel = -1, busy_fix = 0, busy_max = 0;
    int p_rsp = 0, p_lat = 0, p_vrf = 0, p_orphan = 0;
    bit rsp_hold = 1, rsp_rev = 0;

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    function automatic bit rd_cls(int k); return (k == 0 || k == 2 || k == 3); endfunction

    task automatic step();
        int  k, idx;
        bit  e_rdy, e_launch, e_hv, e_ret, e_err, hit, do_push;
        @(negedge clk);
        cyc++;
        // Drive inputs for this cycle.
        req_valid = ($urandom_range(99) < p_req);
        req_kind  = 3'((kind_sel < 0) ? $urandom_range(5) : kind_sel);
        req_busy  = BUSY_W'((busy_fix >= 0) ? busy_fix : $urandom_range(busy_max));
        rsp_valid = 0;
        if (!rsp_hold && pend.size() > 0 && $urandom_range(99) < p_rsp) begin
            idx = rsp_rev ? pend.size() - 1 : $urandom_range(pend.size() - 1);
            rsp_seq = SEQ_W'(pend[idx]);
            pend.delete(idx);
            rsp_valid = 1;
        end else if ($urandom_range(99) < p_orphan) begin
            rsp_seq = SEQ_W'((m_next + 5) & 255);
            rsp_valid = 1;
        end
        lat_ready = ($urandom_range(99) < p_lat);
        vrf_ok    = ($urandom_range(99) < p_vrf);
        #1;
        // Expected outputs from the model state.
        e_rdy = (mq.size() < FD);
        e_launch = 0; k = 0;
        if (mq.size() > 0) begin
            k = mq[0].kind;
            e_launch = !((rd_cls(k) && m_ld >= QSIZE) || (k == 1 && m_st >= QSIZE) ||
                         (k != 5 && ring.size() >= BUFD));
        end
        e_hv  = (ring.size() > 0) && ring[0].done;
        e_ret = e_hv && lat_ready && (m_timer == 0) &&
                (!(ring[0].kind == 0 || ring[0].kind == 3) || vrf_ok);
        hit = 0;
        if (rsp_valid)
            foreach (ring[i]) if (ring[i].seq == int'(rsp_seq) && !ring[i].done) hit = 1;
        e_err = rsp_valid && !hit;

        chk("R2 req_ready", req_ready, e_rdy);
        chk("R2 R3 R4 R6 R11 launch_valid", launch_valid, e_launch);
        if (e_launch) begin
            chk("R2 launch_kind", launch_kind, k);
            if (k != 5) chk("R5 launch_seq", launch_seq, m_next);
        end
        chk("R8 head_valid", head_valid, e_hv);
        if (e_hv) chk("R8 head_seq", head_seq, ring[0].seq);
        chk("R9 R10 retire_valid", retire_valid, e_ret);
        if (e_ret) begin
            chk("R8 retire_seq", retire_seq, ring[0].seq);
            chk("R9 retire_kind", retire_kind, ring[0].kind);
        end
        chk("R7 rsp_err", rsp_err, e_err);

        if (e_launch) launches++;
        if (e_launch && e_ret) both_cnt++;
        if (e_err) err_cnt++;
        if (e_hv && !e_ret) held_cnt++;

        // Advance the model across the coming edge.
        do_push = req_valid && e_rdy;
        if (hit) foreach (ring[i]) if (ring[i].seq == int'(rsp_seq)) ring[i].done = 1;
        if (e_ret) begin
            if (cyc - last_ret < min_gap) min_gap = cyc - last_ret;
            last_ret = cyc;
            m_timer = ring[0].busy;
            if (rd_cls(ring[0].kind)) m_ld--;
            if (ring[0].kind == 1) m_st--;
            void'(ring.pop_front());
        end else if (m_timer > 0) m_timer--;
        if (e_launch) begin
            if (k != 5) begin
                ring.push_back('{m_next, k, mq[0].busy, 1'b0});
                pend.push_back(m_next);
                m_next = (m_next + 1) & 255;
            end
            if (rd_cls(k)) m_ld++;
            if (k == 1) m_st++;
            void'(mq.pop_front());
        end
        if (do_push) mq.push_back('{int'(req_kind), int'(req_busy)});
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic drain();
        p_req = 0; rsp_hold = 0; p_rsp = 100; p_lat = 100; p_vrf = 100; p_orphan = 0;
        run(120);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1 req_ready", req_ready, 1);
        chk("R1 launch_valid", launch_valid, 0);
        chk("R1 head_valid", head_valid, 0);
        chk("R1 retire_valid", retire_valid, 0);
        run(3);

        // Read-class cap, then reverse-order responses.
        kind_sel = 0; busy_fix = 0; p_req = 100; rsp_hold = 1; launches = 0;
        run(20);
        chk("R3 loads launched at cap", launches, QSIZE);
        rsp_rev = 1; drain(); rsp_rev = 0;

        // Write-class cap.
        kind_sel = 1; p_req = 100; rsp_hold = 1; launches = 0;
        run(20);
        chk("R4 stores launched at cap", launches, QSIZE);
        drain();

        // Ring capacity with syncs.
        kind_sel = 4; p_req = 100; rsp_hold = 1; launches = 0;
        run(20);
        chk("R6 syncs launched at ring limit", launches, BUFD);
        drain();

        // End-of-kernel syncs take no entry.
        kind_sel = 5; p_req = 100; rsp_hold = 1; launches = 0;
        run(20);
        chk("R5 end-of-kernel launches not held", launches >= 15, 1);
        drain();

        // Return-bus occupancy.
        kind_sel = 1; busy_fix = 3; p_req = 100; rsp_hold = 0; p_rsp = 100;
        p_lat = 100; p_vrf = 100; min_gap = 1000;
        run(60);
        chk("R10 minimum retire gap", min_gap, 4);
        drain();

        // Mixed random traffic.
        kind_sel = -1; busy_fix = -1; busy_max = 2; p_req = 60; rsp_hold = 0;
        p_rsp = 50; p_lat = 70; p_vrf = 70; p_orphan = 10; both_cnt = 0;
        run(2000);
        drain();
        chk("R12 launch and retire in one cycle seen", both_cnt > 0, 1);
        chk("R7 unmatched responses seen", err_cnt > 0, 1);
        chk("R9 held head seen", held_cnt > 0, 1);
        chk("R11 all entries retired", ring.size() + mq.size(), 0);
        summary();
    end
endmodule